// File: doc/BRIEF.md
# I2C Port Expander

This block is an I2C target that gives a bus controller eight general-purpose I/O pins. Four 8-bit registers sit behind it: a live input view, an output latch, a per-bit polarity mask and a per-bit direction setting. The controller picks one with a command byte, which is the first data byte of a write. Any following data bytes in that write go to the chosen register. A read, whether it follows a repeated start or comes in a later transaction, returns the register named by the most recent command byte.

Each pin is driven from the output latch when its direction bit says output. Otherwise it is left undriven and only observed. Input reads are XORed with the polarity mask. An interrupt line is modelled as an open-drain pull-low enable. It is raised whenever an input-configured pin differs from the snapshot taken at the last input-register read. It drops when that register is read again, or when the pins go back to the snapshot.

SCL and SDA are cleaned by a two-flop synchroniser followed by a three-sample majority vote, so a single-cycle glitch is ignored. The SDA output is a pull-low enable. The hand-off from the bus engine to the register file is a one-cycle strobe with no back-pressure, because the register file accepts a write or a read load in every cycle.

Top module: `i2c_port_expander`

## Requirements
- R1: After reset, every pin is an input (pin_oe = 0x00), pin_o = 0xFF, irq_pull = 0. Reads then return polarity = 0x00, direction = 0xFF and output = 0xFF.
- R2: The target ACKs an address byte only when its upper 7 bits equal {ADDR_HI, addr_sel}. Otherwise it NACKs, ignores the bytes that follow until the next start, and never pulls SDA while idle.
- R3: The command byte's low two bits select the register: 0 = input, 1 = output, 2 = polarity, 3 = direction. The command byte and every data byte written are ACKed, and each data byte is stored in the selected register.
- R4: All four registers can be read. A read returns the register selected by the last command byte, whether the read follows a repeated start or starts a fresh transaction.
- R5: An input-register read returns the synchronised pins XOR the polarity mask, where mask bit 1 inverts that pin.
- R6: Data written with command 0 changes no register and no output.
- R7: Direction bit 1 makes a pin an input (pin_oe bit 0). Direction bit 0 sets pin_oe to 1. pin_o always shows the output register. Neither pin_o nor pin_oe changes except on a register write.
- R8: irq_pull is 1 while any input-configured pin differs from the snapshot. Pins configured as outputs are ignored.
- R9: The snapshot is loaded from the synchronised pins when an input-register read is acknowledged, which clears irq_pull. irq_pull also clears when the pins return to the snapshot value.
- R10: An SCL or SDA pulse lasting a single clock cycle has no effect on the bus state machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Pin levels seen at the pads |
| pin_o | output | 8 | Output register value for the pads |
| pin_oe | output | 8 | Per-pin drive enable, 1 = output |
| irq_pull | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
A corrupted direction or output register shows on pin_oe or pin_o within one clock, and the per-cycle reference comparison catches it on the next quiet cycle. A wrong snapshot or mask appears on irq_pull about three clocks after the pins settle. It also appears in the value of the next input-register read. A wrong bit count or state in the bus engine shows up inside the same byte, as a missing or misplaced ACK or as shifted read data.

// File: rtl/xp_pkg.sv
`timescale 1ns/1ps
package xp_pkg;
  localparam int PW = 8;

  typedef enum logic [1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_DIR = 2'd3
  } xp_reg_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_CMD, S_CMD_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK
  } xp_state_e;
endpackage

// File: rtl/xp_sync.sv
`timescale 1ns/1ps
module xp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/xp_bus_filter.sv
`timescale 1ns/1ps
module xp_bus_filter #(
  parameter int W    = 2,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [SYNC-1:0] sync_q;
    logic [2:0]      win_q;
    logic            vote_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        win_q  <= '1;
        vote_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], raw[i]};
        win_q  <= {win_q[1:0], sync_q[SYNC-1]};
        vote_q <= (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) | (win_q[0] & win_q[2]);
      end
    end

    assign clean[i] = vote_q;
  end
endmodule

// File: rtl/xp_i2c_target.sv
`timescale 1ns/1ps
module xp_i2c_target
  import xp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl,
  input  logic          sda,
  input  logic [6:0]    dev_addr,
  input  logic [PW-1:0] rdata,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic          rd_stb,
  output xp_reg_e       cmd,
  output logic [PW-1:0] wdata,
  output logic          bus_idle
);
  xp_state_e     st;
  logic          scl_q, sda_q;
  logic [2:0]    cnt;
  logic          byte_done, rw, m_nack;
  logic [PW-1:0] shreg, tx;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;

  assign bus_idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      cnt <= '0; byte_done <= 1'b0; rw <= 1'b0; m_nack <= 1'b1;
      shreg <= '0; tx <= '0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; rd_stb <= 1'b0; cmd <= REG_IN; wdata <= '0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; byte_done <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; byte_done <= 1'b0; sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_ADDR, S_CMD, S_WDATA: begin
            shreg <= {shreg[PW-2:0], sda};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) byte_done <= 1'b1;
          end
          S_RDATA: begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) byte_done <= 1'b1;
          end
          S_RACK:  m_nack <= sda;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (byte_done) begin
            byte_done <= 1'b0;
            if (shreg[7:1] == dev_addr) begin
              st <= S_ADDR_ACK; sda_oe <= 1'b1; rw <= shreg[0];
            end else begin
              st <= S_IDLE;
            end
          end
          S_CMD: if (byte_done) begin
            byte_done <= 1'b0; cmd <= xp_reg_e'(shreg[1:0]);
            sda_oe <= 1'b1; st <= S_CMD_ACK;
          end
          S_WDATA: if (byte_done) begin
            byte_done <= 1'b0; sda_oe <= 1'b1; st <= S_WDATA_ACK;
            wr_stb <= 1'b1; wdata <= shreg;
          end
          S_RDATA: begin
            if (byte_done) begin
              byte_done <= 1'b0; sda_oe <= 1'b0; st <= S_RACK;
            end else begin
              sda_oe <= ~tx[PW-2];
              tx     <= {tx[PW-2:0], 1'b0};
            end
          end
          S_ADDR_ACK: begin
            cnt <= '0;
            if (rw) begin
              st <= S_RDATA; tx <= rdata; sda_oe <= ~rdata[PW-1]; rd_stb <= 1'b1;
            end else begin
              st <= S_CMD; sda_oe <= 1'b0;
            end
          end
          S_CMD_ACK, S_WDATA_ACK: begin
            st <= S_WDATA; sda_oe <= 1'b0; cnt <= '0;
          end
          S_RACK: begin
            if (!m_nack) begin
              st <= S_RDATA; cnt <= '0; tx <= rdata;
              sda_oe <= ~rdata[PW-1]; rd_stb <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xp_regfile.sv
`timescale 1ns/1ps
module xp_regfile
  import xp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  xp_reg_e       cmd,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] pins_sync,
  output logic [PW-1:0] rdata,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe,
  output logic          irq_pull
);
  logic [PW-1:0] out_q, pol_q, dir_q, snap_q, diff;
  logic          irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1; pol_q <= '0; dir_q <= '1; snap_q <= '0; irq_q <= 1'b0;
    end else begin
      if (wr_stb) begin
        case (cmd)
          REG_OUT: out_q <= wdata;
          REG_POL: pol_q <= wdata;
          REG_DIR: dir_q <= wdata;
          default: ;
        endcase
      end
      if (rd_stb && cmd == REG_IN) snap_q <= pins_sync;
      irq_q <= |diff;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_pin
    assign pin_oe[i] = ~dir_q[i];
    assign pin_o[i]  = out_q[i];
    assign diff[i]   = dir_q[i] & (pins_sync[i] ^ snap_q[i]);
  end

  always_comb begin
    case (cmd)
      REG_IN:  rdata = pins_sync ^ pol_q;
      REG_OUT: rdata = out_q;
      REG_POL: rdata = pol_q;
      default: rdata = dir_q;
    endcase
  end

  assign irq_pull = irq_q;
endmodule

// File: rtl/i2c_port_expander.sv
`timescale 1ns/1ps
module i2c_port_expander
  import xp_pkg::*;
#(
  parameter logic [3:0] ADDR_HI  = 4'b0111,
  parameter int          BUS_SYNC = 2,
  parameter int          PIN_SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_drive_low,
  input  logic [2:0]    addr_sel,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe,
  output logic          irq_pull
);
  logic [1:0]    bus_clean;
  logic [PW-1:0] pins_sync, rdata, wdata;
  logic          wr_stb, rd_stb, bus_idle;
  xp_reg_e       cmd;

  xp_bus_filter #(.W(2), .SYNC(BUS_SYNC)) u_filter (
    .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}), .clean(bus_clean)
  );

  xp_sync #(.W(PW), .STAGES(PIN_SYNC)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_i), .dout(pins_sync)
  );

  xp_i2c_target u_target (
    .clk(clk), .rst_n(rst_n), .scl(bus_clean[1]), .sda(bus_clean[0]),
    .dev_addr({ADDR_HI, addr_sel}), .rdata(rdata), .sda_oe(sda_drive_low),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .cmd(cmd), .wdata(wdata), .bus_idle(bus_idle)
  );

  xp_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .cmd(cmd),
    .wdata(wdata), .pins_sync(pins_sync), .rdata(rdata),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_pull(irq_pull)
  );
endmodule

// File: rtl/xp_checker.sv
`timescale 1ns/1ps
module xp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe,
  input logic       irq_pull,
  input logic       sda_drive_low,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic [1:0] cmd,
  input logic [7:0] pins_sync,
  input logic       bus_idle
);
  AST_RESET_RELEASE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == 8'h00 && pin_o == 8'hFF && !irq_pull)); // R1

  AST_NO_DRIVE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_drive_low); // R2

  AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cmd == 2'd0) |=> ($stable(pin_o) && $stable(pin_oe))); // R6

  AST_PORTS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(pin_o) && $stable(pin_oe))); // R7

  AST_IRQ_CLEARS_AFTER_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && cmd == 2'd0) ##1 $stable(pins_sync) |=> !irq_pull); // R9
endmodule

bind i2c_port_expander xp_checker u_xp_checker (
  .clk(clk), .rst_n(rst_n), .pin_o(pin_o), .pin_oe(pin_oe), .irq_pull(irq_pull),
  .sda_drive_low(sda_drive_low), .wr_stb(wr_stb), .rd_stb(rd_stb), .cmd(cmd),
  .pins_sync(pins_sync), .bus_idle(bus_idle)
);

// File: tb/i2c_port_expander_tb_top.sv
`timescale 1ns/1ps
module i2c_port_expander_tb_top;
  localparam int Q = 16;
  localparam logic [3:0] AHI = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_low = 1'b0;
  logic [2:0] addr_sel = 3'b101;
  logic [7:0] pins = 8'h00;
  logic [7:0] pin_o, pin_oe;
  logic sda_drive_low, irq_pull;
  wire  sda_line = ~(sda_low | sda_drive_low);

  always #10 clk = ~clk; // 50 MHz

  i2c_port_expander dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .addr_sel(addr_sel), .pin_i(pins),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_pull(irq_pull)
  );

  // behavioural model state
  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_dir = 8'hFF, m_snap = 8'h00;
  logic [1:0] m_cmd = 2'd0;
  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0, wd_fail = 0;
  int cyc = 0, hold_until = 40;
  logic busy = 1'b1, done = 1'b0, glitch_once = 1'b0;

  // per-cycle comparison against the model while the bus is quiet
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && !busy && cyc > hold_until) begin
      mon_chk = mon_chk + 1;
      if (pin_o !== m_out || pin_oe !== ~m_dir ||
          irq_pull !== (|((pins ^ m_snap) & m_dir))) begin
        mon_fail = mon_fail + 1;
        $display("FAIL R7 R8 cycle %0d: actual o=%h oe=%h irq=%b expected o=%h oe=%h irq=%b",
                 cyc, pin_o, pin_oe, irq_pull, m_out, ~m_dir, |((pins ^ m_snap) & m_dir));
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; wait_q(); scl_drv = 1'b1; wait_q();
    sda_low = 1'b1; wait_q(); scl_drv = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; wait_q(); scl_drv = 1'b1; wait_q();
    sda_low = 1'b0; wait_q(); wait_q();
  endtask

  task automatic send_bit(input logic b);
    sda_low = !b;
    repeat (Q/2) @(negedge clk);
    if (glitch_once) begin
      glitch_once = 1'b0;
      scl_drv = 1'b1; @(negedge clk); scl_drv = 1'b0;
    end
    repeat (Q/2) @(negedge clk);
    scl_drv = 1'b1; wait_q(); wait_q(); scl_drv = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output logic b);
    sda_low = 1'b0; wait_q(); scl_drv = 1'b1; wait_q();
    b = sda_line; wait_q(); scl_drv = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!ack);
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] c);
    case (c)
      2'd0:    return pins ^ m_pol;
      2'd1:    return m_out;
      2'd2:    return m_pol;
      default: return m_dir;
    endcase
  endfunction

  task automatic finish_txn();
    busy = 1'b0; hold_until = cyc + 12;
  endtask

  task automatic wr_reg(input logic [1:0] c, input logic [7:0] d, input string tag);
    logic a;
    busy = 1'b1;
    bus_start();
    send_byte({AHI, addr_sel, 1'b0}, a); chk(a, {tag, " R2 address ACK"}, {7'd0, a}, 8'd1);
    send_byte({6'd0, c}, a);             chk(a, {tag, " R3 command ACK"}, {7'd0, a}, 8'd1);
    send_byte(d, a);                     chk(a, {tag, " R3 data ACK"}, {7'd0, a}, 8'd1);
    bus_stop();
    m_cmd = c;
    case (c)
      2'd1: m_out = d;
      2'd2: m_pol = d;
      2'd3: m_dir = d;
      default: ; // R6: input register ignores writes
    endcase
    finish_txn();
  endtask

  task automatic rd_reg(input logic [1:0] c, input string tag);
    logic a;
    logic [7:0] d, e;
    busy = 1'b1;
    bus_start();
    send_byte({AHI, addr_sel, 1'b0}, a); chk(a, {tag, " R2 address ACK"}, {7'd0, a}, 8'd1);
    send_byte({6'd0, c}, a);             chk(a, {tag, " R3 command ACK"}, {7'd0, a}, 8'd1);
    m_cmd = c;
    e = model_read(c);
    bus_start();
    send_byte({AHI, addr_sel, 1'b1}, a); chk(a, {tag, " R4 read address ACK"}, {7'd0, a}, 8'd1);
    recv_byte(d, 1'b0);
    bus_stop();
    chk(d == e, tag, d, e);
    if (c == 2'd0) m_snap = pins;
    finish_txn();
  endtask

  task automatic rd_cur(input string tag);
    logic a;
    logic [7:0] d, e;
    busy = 1'b1;
    e = model_read(m_cmd);
    bus_start();
    send_byte({AHI, addr_sel, 1'b1}, a); chk(a, {tag, " R4 read address ACK"}, {7'd0, a}, 8'd1);
    recv_byte(d, 1'b0);
    bus_stop();
    chk(d == e, tag, d, e);
    if (m_cmd == 2'd0) m_snap = pins;
    finish_txn();
  endtask

  task automatic set_pins(input logic [7:0] v);
    pins = v; hold_until = cyc + 12;
  endtask

  task automatic settle_check_irq(input logic exp, input string tag);
    repeat (14) @(negedge clk);
    chk(irq_pull == exp, tag, {7'd0, irq_pull}, {7'd0, exp});
  endtask

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    busy = 1'b0;
    // R1 reset state at the ports and through reads
    chk(pin_oe == 8'h00, "R1 pin_oe after reset", pin_oe, 8'h00);
    chk(pin_o == 8'hFF, "R1 pin_o after reset", pin_o, 8'hFF);
    chk(irq_pull == 1'b0, "R1 irq after reset", {7'd0, irq_pull}, 8'd0);
    rd_reg(2'd3, "R1 direction default");
    rd_reg(2'd2, "R1 polarity default");
    rd_reg(2'd1, "R1 output default");
    // R3 R4 write then read back each writable register
    wr_reg(2'd1, 8'h5A, "R3 output write");
    rd_reg(2'd1, "R4 output readback");
    wr_reg(2'd2, 8'hA5, "R3 polarity write");
    rd_reg(2'd2, "R4 polarity readback");
    wr_reg(2'd3, 8'h0F, "R3 direction write");
    rd_reg(2'd3, "R4 direction readback");
    repeat (14) @(negedge clk);
    chk(pin_oe == 8'hF0, "R7 pin_oe from direction", pin_oe, 8'hF0);
    chk(pin_o == 8'h5A, "R7 pin_o from output reg", pin_o, 8'h5A);
    // R8 R5 R9 interrupt and polarity
    set_pins(8'h3C);
    settle_check_irq(1'b1, "R8 input change raises irq");
    rd_reg(2'd0, "R5 inverted input read");
    settle_check_irq(1'b0, "R9 read clears irq");
    set_pins(8'hBC);
    settle_check_irq(1'b0, "R8 output-pin change ignored");
    set_pins(8'hBD);
    settle_check_irq(1'b1, "R8 input bit0 change");
    set_pins(8'hBC);
    settle_check_irq(1'b0, "R9 return to snapshot clears");
    // R6 write to input register has no effect
    wr_reg(2'd0, 8'h55, "R6 input write");
    rd_reg(2'd0, "R6 input read after write");
    rd_reg(2'd1, "R6 output unchanged");
    rd_reg(2'd2, "R6 polarity unchanged");
    // R5 non-inverted path
    wr_reg(2'd2, 8'h00, "R5 clear polarity");
    rd_reg(2'd0, "R5 plain input read");
    // R4 read without new command byte
    wr_reg(2'd2, 8'h33, "R4 set polarity");
    rd_cur("R4 current-register read");
    // R2 address mismatch
    busy = 1'b1;
    bus_start();
    send_byte({AHI, addr_sel ^ 3'b001, 1'b0}, a);
    chk(!a, "R2 wrong address NACK", {7'd0, a}, 8'd0);
    send_byte(8'h01, a);
    chk(!a, "R2 ignored command NACK", {7'd0, a}, 8'd0);
    send_byte(8'h00, a);
    bus_stop();
    finish_txn();
    rd_reg(2'd1, "R2 output unchanged after mismatch");
    addr_sel = 3'b010;
    wr_reg(2'd3, 8'hFF, "R2 new address select");
    rd_reg(2'd3, "R2 read at new address");
    // R10 one-cycle SCL glitch during the address byte
    glitch_once = 1'b1;
    wr_reg(2'd1, 8'hC3, "R10 glitched write");
    rd_reg(2'd1, "R10 value after glitch");
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + mon_chk + 1, n_fail + mon_fail + wd_fail);
      $finish;
    end
  end
endmodule